// File: doc/BRIEF.md
# Debug Trigger Match Unit

This block compares each memory access or instruction fetch of a 64-bit core against a small bank of programmable debug triggers. Software programs every trigger slot through a plain register write port: a control word chooses which operation types and privilege levels the slot watches, and whether it looks at the access address or the data value. The control word also sets a compare mode, a chain bit and an action code. A second word per slot holds the 64-bit compare value.

On every access the core presents the operation type, address, data, current privilege level, a narrow-mode flag for 32-bit operation and a debug-mode flag. One clock later the block reports whether a trigger fired, which slot fired, and the action code stored in that slot. Raising the exception or entering the halted state is the core's job.

Six compare modes are offered: exact equality, a naturally aligned power-of-two range whose size comes from the run of ones at the bottom of the compare value, unsigned greater-or-equal, unsigned less-than, and two masked modes that test either half of the value against a pattern and mask packed into the compare value. Slots can be chained, so that a group of adjacent slots fires only when all of its members match.

Top module: `trig_match_unit`

## Requirements
- R1: After synchronous reset, hit_o, idx_o and action_o are 0, and every slot's control word and compare value are 0, so no request can hit until a slot is written.
- R2: While dbg_mode is high, the response to that request has hit_o = 0.
- R3: Control bits 0, 1 and 2 enable matching for req_op = 0 (execute), 1 (load) and 2 (store). A slot whose bit for the presented operation is clear never matches, and req_op = 3 matches no slot.
- R4: Control bits 3, 4, 5 and 6 enable matching at req_priv = 0 (user), 1 (supervisor), 2 (hypervisor) and 3 (machine). A slot whose bit for the presented level is clear never matches.
- R5: Control bit 7 selects the compared value: req_data when 1, req_addr when 0.
- R6: When narrow_mode is 1, bits 63:32 of the compared value are taken as 0 before comparison. The compare value is used unchanged.
- R7: Compare mode (control bits 10:8) 0 matches when the value equals the compare value.
- R8: Mode 1 counts n, the number of consecutive ones from bit 0 of the compare value. The value matches when all bits at position n and above equal those of the compare value. An all-ones compare value matches any value.
- R9: Mode 2 matches when the value is unsigned greater than or equal to the compare value. Mode 3 matches when it is unsigned less than it. Modes 6 and 7 never match.
- R10: Let M be bits 63:32 and P be bits 31:0 of the compare value. Mode 4 matches when the value's bits 31:0 AND M equal P AND M. Mode 5 matches when the value's bits 63:32 AND M equal P AND M.
- R11: Control bit 11 is the chain bit. A group is a run of slots ending at a slot with chain 0. A hit is reported at that end slot only when every slot of the group matches. A failing group does not stop evaluation of later groups. A trailing group whose last slot has chain 1 never hits.
- R12: The response appears on the clock edge after the request. With req_valid high and several groups hitting, the lowest end slot is reported, with idx_o giving its index and action_o giving its control bits 14:12. When there is no hit (including req_valid low), idx_o and action_o are 0.
- R13: wr_en with wr_sel = 0 writes wr_data[14:0] as the control word of slot wr_idx; with wr_sel = 1 it writes wr_data as the compare value. A request presented in the same cycle as a write still sees the old contents, and requests from the next cycle on see the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 2 | Slot written |
| wr_sel | input | 1 | 0: control word, 1: compare value |
| wr_data | input | 64 | Write data |
| req_valid | input | 1 | An access is presented this cycle |
| req_op | input | 2 | 0 execute, 1 load, 2 store |
| req_priv | input | 2 | 0 user, 1 supervisor, 2 hypervisor, 3 machine |
| req_addr | input | 64 | Access address |
| req_data | input | 64 | Access data |
| narrow_mode | input | 1 | Core runs in 32-bit mode |
| dbg_mode | input | 1 | Core is in debug mode |
| hit_o | output | 1 | A trigger fired (registered) |
| idx_o | output | 2 | Index of the firing slot |
| action_o | output | 3 | Action code of the firing slot |

## Verification
The bench builds the block with its default values: four slots and a 64-bit datapath. With these values all six compare modes, both halves of the masked modes and the 32-bit truncation boundary can be reached. Four slots also allow chains of two and three links beside an independent group. Random compare values are used as the addresses and data of later requests, so real hits and near misses occur often enough for chains and the priority between groups to be exercised.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam int OP_W   = 2;
  localparam int PRIV_W = 2;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 3;

  localparam logic [MODE_W-1:0] CMP_EQ    = 3'd0;
  localparam logic [MODE_W-1:0] CMP_NAPOT = 3'd1;
  localparam logic [MODE_W-1:0] CMP_GE    = 3'd2;
  localparam logic [MODE_W-1:0] CMP_LT    = 3'd3;
  localparam logic [MODE_W-1:0] CMP_MLOW  = 3'd4;
  localparam logic [MODE_W-1:0] CMP_MHIGH = 3'd5;

  // Packed MSB first: action[14:12] chain[11] mode[10:8] sel[7]
  // priv_en[6:3] (indexed by privilege) op_en[2:0] (indexed by op)
  typedef struct packed {
    logic [ACT_W-1:0]  action;
    logic              chain;
    logic [MODE_W-1:0] mode;
    logic              sel;
    logic [3:0]        priv_en;
    logic [2:0]        op_en;
  } trig_ctrl_t;

  localparam int CTRL_W = $bits(trig_ctrl_t);

endpackage

// File: rtl/trig_slot_regs.sv
module trig_slot_regs
  import trig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 64,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_sel,
  input  logic [XLEN-1:0]  wr_data,
  output trig_ctrl_t       ctrl_o [NUM_SLOTS],
  output logic [XLEN-1:0]  cmp_o  [NUM_SLOTS]
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic hit_this;
    assign hit_this = wr_en && (wr_idx == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_o[s] <= '0;
        cmp_o[s]  <= '0;
      end else if (hit_this) begin
        if (wr_sel) cmp_o[s]  <= wr_data;
        else        ctrl_o[s] <= trig_ctrl_t'(wr_data[CTRL_W-1:0]);
      end
    end
  end

endmodule

// File: rtl/trig_slot_cmp.sv
module trig_slot_cmp
  import trig_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  localparam int HALF  = XLEN / 2
) (
  input  trig_ctrl_t        ctrl,
  input  logic [XLEN-1:0]   cmp,
  input  logic [OP_W-1:0]   op,
  input  logic [PRIV_W-1:0] priv,
  input  logic [XLEN-1:0]   addr,
  input  logic [XLEN-1:0]   data,
  input  logic              narrow,
  output logic              match_o
);

  logic [XLEN-1:0] raw_val;
  logic [XLEN-1:0] val;
  logic [XLEN-1:0] keep_mask;
  logic [HALF-1:0] half_mask;
  logic [HALF-1:0] half_pat;
  logic            op_ok;
  logic            priv_ok;
  logic            cmp_ok;

  assign raw_val   = ctrl.sel ? data : addr;
  assign val       = narrow ? {{(XLEN-NARROW){1'b0}}, raw_val[NARROW-1:0]} : raw_val;
  // Bits in the bottom run of ones are don't-care in the aligned range mode.
  assign keep_mask = ~(cmp & ~(cmp + XLEN'(1)));
  assign half_mask = cmp[XLEN-1:HALF];
  assign half_pat  = cmp[HALF-1:0];

  always_comb begin
    unique case (op)
      2'd0:    op_ok = ctrl.op_en[0];
      2'd1:    op_ok = ctrl.op_en[1];
      2'd2:    op_ok = ctrl.op_en[2];
      default: op_ok = 1'b0;
    endcase
  end

  assign priv_ok = ctrl.priv_en[priv];

  always_comb begin
    case (ctrl.mode)
      CMP_EQ:    cmp_ok = (val == cmp);
      CMP_NAPOT: cmp_ok = (((val ^ cmp) & keep_mask) == '0);
      CMP_GE:    cmp_ok = (val >= cmp);
      CMP_LT:    cmp_ok = (val < cmp);
      CMP_MLOW:  cmp_ok = (((val[HALF-1:0] ^ half_pat) & half_mask) == '0);
      CMP_MHIGH: cmp_ok = (((val[XLEN-1:HALF] ^ half_pat) & half_mask) == '0);
      default:   cmp_ok = 1'b0;
    endcase
  end

  assign match_o = op_ok && priv_ok && cmp_ok;

endmodule

// File: rtl/trig_chain_pick.sv
module trig_chain_pick #(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] match_i,
  input  logic [NUM_SLOTS-1:0] chain_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);

  always_comb begin
    logic group_ok;
    logic link_ok;
    group_ok = 1'b1;
    found_o  = 1'b0;
    idx_o    = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      link_ok = group_ok && match_i[s];
      if (!chain_i[s]) begin
        if (link_ok && !found_o) begin
          found_o = 1'b1;
          idx_o   = IDX_W'(s);
        end
        group_ok = 1'b1;
      end else begin
        group_ok = link_ok;
      end
    end
  end

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import trig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int XLEN      = 64,
  parameter int NARROW    = 32,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_sel,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              req_valid,
  input  logic [OP_W-1:0]   req_op,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic [XLEN-1:0]   req_addr,
  input  logic [XLEN-1:0]   req_data,
  input  logic              narrow_mode,
  input  logic              dbg_mode,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ACT_W-1:0]  action_o
);

  trig_ctrl_t             slot_ctrl [NUM_SLOTS];
  logic [XLEN-1:0]        slot_cmp  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0]   slot_match;
  logic [NUM_SLOTS-1:0]   slot_chain;
  logic                   found;
  logic [IDX_W-1:0]       found_idx;

  trig_slot_regs #(.NUM_SLOTS(NUM_SLOTS), .XLEN(XLEN)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctrl_o  (slot_ctrl),
    .cmp_o   (slot_cmp)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    trig_slot_cmp #(.XLEN(XLEN), .NARROW(NARROW)) u_cmp (
      .ctrl    (slot_ctrl[s]),
      .cmp     (slot_cmp[s]),
      .op      (req_op),
      .priv    (req_priv),
      .addr    (req_addr),
      .data    (req_data),
      .narrow  (narrow_mode),
      .match_o (slot_match[s])
    );
    assign slot_chain[s] = slot_ctrl[s].chain;
  end

  trig_chain_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
    .match_i (slot_match),
    .chain_i (slot_chain),
    .found_o (found),
    .idx_o   (found_idx)
  );

  logic fire;
  assign fire = req_valid && !dbg_mode && found;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o    <= 1'b0;
      idx_o    <= '0;
      action_o <= '0;
    end else begin
      hit_o    <= fire;
      idx_o    <= fire ? found_idx : '0;
      action_o <= fire ? slot_ctrl[found_idx].action : '0;
    end
  end

endmodule

// File: rtl/trig_match_unit_chk.sv
module trig_match_unit_chk
  import trig_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [OP_W-1:0]   req_op,
  input logic [PRIV_W-1:0] req_priv,
  input logic              dbg_mode,
  input logic              hit_o,
  input logic [IDX_W-1:0]  idx_o,
  input logic [ACT_W-1:0]  action_o,
  input trig_ctrl_t        slot_ctrl [NUM_SLOTS]
);

  logic [NUM_SLOTS-1:0] chain_prev;
  logic [NUM_SLOTS-1:0] op_ok_prev;
  logic [NUM_SLOTS-1:0] priv_ok_prev;
  logic [ACT_W-1:0]     act_prev [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_prev[s]   <= 1'b0;
        op_ok_prev[s]   <= 1'b0;
        priv_ok_prev[s] <= 1'b0;
        act_prev[s]     <= '0;
      end else begin
        chain_prev[s]   <= slot_ctrl[s].chain;
        op_ok_prev[s]   <= (req_op != 2'd3) && slot_ctrl[s].op_en[req_op];
        priv_ok_prev[s] <= slot_ctrl[s].priv_en[req_priv];
        act_prev[s]     <= slot_ctrl[s].action;
      end
    end
  end

  AST_DEBUG_QUIET: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |=> !hit_o); // R2
  AST_OP_ENABLED: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> op_ok_prev[idx_o]); // R3
  AST_PRIV_ENABLED: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> priv_ok_prev[idx_o]); // R4
  AST_CHAIN_END: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> !chain_prev[idx_o]); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !hit_o); // R12
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit_o |-> (idx_o == '0 && action_o == '0)); // R12
  AST_ACTION_SOURCE: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> action_o == act_prev[idx_o]); // R12

endmodule

bind trig_match_unit trig_match_unit_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_priv  (req_priv),
  .dbg_mode  (dbg_mode),
  .hit_o     (hit_o),
  .idx_o     (idx_o),
  .action_o  (action_o),
  .slot_ctrl (slot_ctrl)
);

// File: tb/trig_match_unit_test.sv
module trig_match_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [1:0]  wr_idx;
  logic        wr_sel;
  logic [63:0] wr_data;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [1:0]  req_priv;
  logic [63:0] req_addr;
  logic [63:0] req_data;
  logic        narrow_mode;
  logic        dbg_mode;
  logic        hit_o;
  logic [1:0]  idx_o;
  logic [2:0]  action_o;

  int checks = 0;
  int errors = 0;

  logic [14:0] sh_ctrl [NS];
  logic [63:0] sh_cmp  [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_match_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_op(req_op),
    .req_priv(req_priv), .req_addr(req_addr), .req_data(req_data),
    .narrow_mode(narrow_mode), .dbg_mode(dbg_mode),
    .hit_o(hit_o), .idx_o(idx_o), .action_o(action_o)
  );

  function automatic logic [14:0] mk(input logic [2:0] ope, input logic [3:0] pe,
                                     input logic sel, input logic [2:0] md,
                                     input logic ch, input logic [2:0] act);
    return {act, ch, md, sel, pe, ope};
  endfunction

  function automatic logic slot_hits(input int s, input logic [1:0] op, input logic [1:0] pv,
                                     input logic [63:0] a, input logic [63:0] d, input logic m32);
    logic [14:0] c;
    logic [63:0] v, t, mask;
    int n;
    logic ok;
    c = sh_ctrl[s];
    t = sh_cmp[s];
    if (op == 2'd3) return 1'b0;
    if (!c[op]) return 1'b0;
    if (!c[3 + pv]) return 1'b0;
    v = c[7] ? d : a;
    if (m32) v = v & 64'h0000_0000_FFFF_FFFF;
    n = 0;
    while (n < 64 && t[n]) n++;
    mask = (n >= 64) ? 64'd0 : ~((64'd1 << n) - 64'd1);
    case (c[10:8])
      3'd0: ok = (v == t);
      3'd1: ok = ((v & mask) == (t & mask));
      3'd2: ok = (v >= t);
      3'd3: ok = (v < t);
      3'd4: ok = ((v[31:0] & t[63:32]) == (t[31:0] & t[63:32]));
      3'd5: ok = ((v[63:32] & t[63:32]) == (t[31:0] & t[63:32]));
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic void model(input logic vld, input logic [1:0] op, input logic [1:0] pv,
                                input logic [63:0] a, input logic [63:0] d,
                                input logic m32, input logic dbg,
                                output logic eh, output logic [1:0] ei, output logic [2:0] ea);
    logic all_ok;
    eh = 0; ei = 0; ea = 0;
    if (!vld || dbg) return;
    all_ok = 1;
    for (int s = 0; s < NS; s++) begin
      all_ok = all_ok & slot_hits(s, op, pv, a, d, m32);
      if (!sh_ctrl[s][11]) begin
        if (all_ok && !eh) begin
          eh = 1; ei = 2'(s); ea = sh_ctrl[s][14:12];
        end
        all_ok = 1;
      end
    end
  endfunction

  task automatic compare(input string tag, input logic eh, input logic [1:0] ei, input logic [2:0] ea);
    checks++;
    if (hit_o !== eh || idx_o !== ei || action_o !== ea) begin
      errors++;
      $display("FAIL %s: got hit=%0b idx=%0d act=%0d, expected hit=%0b idx=%0d act=%0d",
               tag, hit_o, idx_o, action_o, eh, ei, ea);
    end
  endtask

  task automatic wr(input int s, input logic sel, input logic [63:0] v);
    @(negedge clk);
    wr_en = 1; wr_idx = 2'(s); wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 0;
    if (sel) sh_cmp[s] = v; else sh_ctrl[s] = v[14:0];
  endtask

  task automatic set_slot(input int s, input logic [14:0] c, input logic [63:0] t);
    wr(s, 1'b0, {49'd0, c});
    wr(s, 1'b1, t);
  endtask

  task automatic clear_all();
    for (int s = 0; s < NS; s++) set_slot(s, 15'd0, 64'd0);
  endtask

  task automatic req(input string tag, input logic vld, input logic [1:0] op, input logic [1:0] pv,
                     input logic [63:0] a, input logic [63:0] d, input logic m32, input logic dbg);
    logic eh; logic [1:0] ei; logic [2:0] ea;
    @(negedge clk);
    req_valid = vld; req_op = op; req_priv = pv; req_addr = a; req_data = d;
    narrow_mode = m32; dbg_mode = dbg;
    model(vld, op, pv, a, d, m32, dbg, eh, ei, ea);
    @(negedge clk);
    req_valid = 0;
    compare(tag, eh, ei, ea);
  endtask

  task automatic req_exp(input string tag, input logic [63:0] a, input logic [63:0] d,
                         input logic m32, input logic eh, input logic [1:0] ei, input logic [2:0] ea);
    @(negedge clk);
    req_valid = 1; req_op = 0; req_priv = 3; req_addr = a; req_data = d;
    narrow_mode = m32; dbg_mode = 0;
    @(negedge clk);
    req_valid = 0;
    compare(tag, eh, ei, ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [14:0] EQ_X_M = 15'h1041; // exec, machine, eq, action 1

  initial begin
    void'($urandom(32'd1234));
    rst = 1; wr_en = 0; wr_idx = 0; wr_sel = 0; wr_data = 0;
    req_valid = 0; req_op = 0; req_priv = 0; req_addr = 0; req_data = 0;
    narrow_mode = 0; dbg_mode = 0;
    for (int s = 0; s < NS; s++) begin sh_ctrl[s] = 0; sh_cmp[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    compare("R1 reset outputs", 0, 0, 0);
    req_exp("R1 cleared slots", 64'd0, 64'd0, 0, 0, 0, 0);

    // R7 equal
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd0, 0, 3'd1), 64'h1000);
    req_exp("R7 equal hit", 64'h1000, 0, 0, 1, 0, 1);
    req_exp("R7 equal miss", 64'h1001, 0, 0, 0, 0, 0);
    // R3 operation enable
    req("R3 load on exec-only slot", 1, 2'd1, 2'd3, 64'h1000, 0, 0, 0);
    req("R3 op 3", 1, 2'd3, 2'd3, 64'h1000, 0, 0, 0);
    // R4 privilege enable
    req("R4 user on machine-only slot", 1, 2'd0, 2'd0, 64'h1000, 0, 0, 0);
    // R2 debug mode
    req("R2 debug mode", 1, 2'd0, 2'd3, 64'h1000, 0, 0, 1);
    // R12 valid low
    req("R12 valid low", 0, 2'd0, 2'd3, 64'h1000, 0, 0, 0);
    // R13 write in the same cycle as a request
    @(negedge clk);
    wr_en = 1; wr_idx = 0; wr_sel = 1; wr_data = 64'h77;
    req_valid = 1; req_op = 0; req_priv = 3; req_addr = 64'h77; req_data = 0;
    narrow_mode = 0; dbg_mode = 0;
    @(negedge clk);
    wr_en = 0; sh_cmp[0] = 64'h77;
    compare("R13 same-cycle write sees old value", 0, 0, 0);
    @(negedge clk);
    compare("R13 next-cycle sees new value", 1, 0, 1);
    req_valid = 0;

    // R5 select
    set_slot(0, mk(3'b001, 4'b1000, 1, 3'd0, 0, 3'd2), 64'hABCD);
    req_exp("R5 data selected hit", 64'h0, 64'hABCD, 0, 1, 0, 2);
    req_exp("R5 address ignored", 64'hABCD, 64'h0, 0, 0, 0, 0);
    // R6 narrow mode
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd0, 0, 3'd3), 64'h8000_0000);
    req_exp("R6 narrow truncates", 64'hFFFF_FFFF_8000_0000, 0, 1, 1, 0, 3);
    req_exp("R6 wide keeps upper", 64'hFFFF_FFFF_8000_0000, 0, 0, 0, 0, 0);
    // R8 aligned range
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd1, 0, 3'd4), 64'h20FF);
    req_exp("R8 range low end", 64'h2000, 0, 0, 1, 0, 4);
    req_exp("R8 range high end", 64'h20FF, 0, 0, 1, 0, 4);
    req_exp("R8 range outside", 64'h2100, 0, 0, 0, 0, 0);
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd1, 0, 3'd4), 64'hFFFF_FFFF_FFFF_FFFF);
    req_exp("R8 all ones", 64'h1234_5678_9ABC_DEF0, 0, 0, 1, 0, 4);
    // R9 ordering modes
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd2, 0, 3'd5), 64'h500);
    req_exp("R9 ge equal", 64'h500, 0, 0, 1, 0, 5);
    req_exp("R9 ge below", 64'h4FF, 0, 0, 0, 0, 0);
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd3, 0, 3'd5), 64'h500);
    req_exp("R9 lt below", 64'h4FF, 0, 0, 1, 0, 5);
    req_exp("R9 lt equal", 64'h500, 0, 0, 0, 0, 0);
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd6, 0, 3'd5), 64'h500);
    req_exp("R9 reserved mode", 64'h500, 0, 0, 0, 0, 0);
    // R10 masked modes
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd4, 0, 3'd6), 64'h0000_FF00_0000_1200);
    req_exp("R10 low half hit", 64'hDEAD_0000_5512_AB, 0, 0, 1, 0, 6);
    req_exp("R10 low half miss", 64'h13AB, 0, 0, 0, 0, 0);
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd5, 0, 3'd6), 64'h0000_FF00_0000_1200);
    req_exp("R10 high half hit", 64'h0000_12CD_0000_0000, 0, 0, 1, 0, 6);
    req_exp("R10 high half miss", 64'h0000_13CD_0000_1200, 0, 0, 0, 0, 0);

    // R11 chains
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd0, 1, 3'd1), 64'h10);
    set_slot(1, mk(3'b001, 4'b1000, 1, 3'd0, 0, 3'd2), 64'h20);
    set_slot(2, mk(3'b001, 4'b1000, 0, 3'd0, 0, 3'd3), 64'h10);
    set_slot(3, mk(3'b001, 4'b1000, 0, 3'd0, 1, 3'd4), 64'h99);
    req_exp("R11 full chain hits at end", 64'h10, 64'h20, 0, 1, 1, 2);
    req_exp("R11 broken link resumes later", 64'h10, 64'h21, 0, 1, 2, 3);
    req_exp("R11 trailing chained slot", 64'h99, 64'h0, 0, 0, 0, 0);
    // R12 priority
    set_slot(0, mk(3'b001, 4'b1000, 0, 3'd2, 0, 3'd5), 64'h0);
    req_exp("R12 lowest slot wins", 64'h10, 64'h20, 0, 1, 0, 5);

    // Random mix
    for (int k = 0; k < 1500; k++) begin
      if (k % 40 == 0) begin
        for (int s = 0; s < NS; s++) begin
          logic [14:0] c;
          logic [63:0] t;
          c = 15'($urandom);
          c[10:8] = 3'($urandom % 7);
          if ($urandom % 3 != 0) c[11] = 0;
          c[6:0] = c[6:0] | 7'($urandom);
          t = {$urandom, $urandom};
          if ($urandom % 4 == 0) t = t & 64'hFFFF_FFFF;
          if (c[10:8] == 3'd1) t = (t & ~64'hFFFF) | ((64'd1 << ($urandom % 16)) - 64'd1);
          set_slot(s, c, t);
        end
      end
      begin
        int s;
        logic [63:0] a, d;
        s = int'($urandom % NS);
        a = ($urandom % 2) ? sh_cmp[s] : {$urandom, $urandom};
        d = ($urandom % 2) ? sh_cmp[int'($urandom % NS)] : {$urandom, $urandom};
        if ($urandom % 4 == 0) a = a ^ (64'd1 << ($urandom % 64));
        if ($urandom % 5 == 0) a[63:32] = 32'hFFFF_FFFF;
        req("R12 random", ($urandom % 8) != 0, 2'($urandom), 2'($urandom), a, d,
            ($urandom % 4) == 0, ($urandom % 8) == 0);
      end
    end

    clear_all();
    req_exp("R1 after clearing", 64'h10, 64'h20, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule